// File: doc/BRIEF.md
# Nibble-Loaded IRQ Counter and Bank Register Decoder

This block decodes CPU writes into the upper half of a cartridge address space. It holds the registers a cartridge needs to pick program and character banks. It also runs an interval timer that raises an interrupt after a programmable number of CPU cycles. The block produces the bank numbers and a mirroring select for the memory-mapping logic next to it. It does not do any mapping itself.

The timer's reload value is 16 bits wide. Four separate writes load it, each supplying one nibble. A 16-bit up-counter advances on every CPU clock enable while the timer is running. When the counter wraps past its maximum, it reloads from the latch and raises the interrupt. The interrupt stays raised until software acknowledges it.

There are four 5-bit program banks, and each one is written in two parts. A selector register chooses which bank's low four bits the next high-range write replaces. Bit 4 of each bank is written separately, through a direct address.

Top module: `bank_irq_decoder`

## Requirements
- R1: After reset, all of the following are zero: every program bank, every character bank, the mirroring output, the interrupt output, the selector, the enable register, the reload latch and the counter.
- R2: A write whose address bits 15:12 are 0x8, 0x9, 0xA or 0xB replaces reload-latch bits 3:0, 7:4, 11:8 or 15:12 respectively. The new bits come from data bits 3:0, and data bits 7:4 are ignored.
- R3: A write with address bits 15:12 equal to 0xC loads the enable register with data bits 2:0 and clears the interrupt. If data bit 1 is set, the same write also loads the counter from the reload latch.
- R4: While enable bit 1 is set and there is no write to 0xC this cycle, each cycle with `cpu_ce` high adds one to the counter. On the tick that finds the counter at 0xFFFF, the counter reloads from the latch and the interrupt goes high.
- R5: A write with address bits 15:12 equal to 0xD clears the interrupt and copies enable bit 0 into enable bit 1. This either resumes or stops counting.
- R6: A write with address bits 15:12 equal to 0xE loads the selector from data bits 3:0. On a later write with address bits 15:12 equal to 0xF, if the selector is 1, 2, 3 or 4, program bank (selector−1) takes data bits 3:0 as its bits 3:0 and keeps its bit 4. Any other selector value leaves every bank's low nibble unchanged.
- R7: A write to 0xF000–0xF3FF sets bit 4 of program bank (address bits 1:0) to data bit 4.
- R8: A write to 0xF800–0xFBFF sets the mirroring output to data bit 0. A write to 0xFC00–0xFFFF stores the whole data byte into character bank (address bits 2:0).
- R9: A write to 0xF400–0xF7FF changes nothing other than the low-nibble update of R6.
- R10: A write with address bit 15 clear changes no register.
- R11: The interrupt stays high until a 0xC or 0xD write clears it. Cycles with `cpu_ce` low and no write leave both the counter and the interrupt unchanged.
- R12: The outputs pack program bank i into `prg_banks[5*i+4:5*i]` and character bank i into `chr_banks[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | One-cycle CPU clock enable that advances the counter |
| wr_en | input | 1 | Write strobe, one cycle per CPU write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| prg_banks | output | 20 | Four 5-bit program bank numbers |
| chr_banks | output | 64 | Eight 8-bit character bank numbers |
| mirror | output | 1 | Mirroring select |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that each CPU write is a single-cycle `wr_en` pulse with stable address and data. They also assume that on cycles with neither `cpu_ce` nor `wr_en`, nothing should change. The stimulus keeps `cpu_ce` low during every write, so the interaction between a tick and a write arises only where a test intends it. A tick therefore never collides with a 0xC reload. Timer behaviour is observed only at the `irq` pin: the bench loads a latch value near 0xFFFF and counts the exact number of enable pulses before the interrupt rises.

// File: rtl/bank_irq_decoder.sv
module bank_irq_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_ce,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output logic [19:0] prg_banks,
  output logic [63:0] chr_banks,
  output logic        mirror,
  output logic        irq
);
  localparam int PRG_N = 4;
  localparam int PRG_W = 5;
  localparam int CHR_N = 8;
  localparam int CHR_W = 8;
  localparam int CNT_W = 16;

  logic [CNT_W-1:0] latch_q, cnt_q;
  logic [2:0]       en_q;
  logic [3:0]       sel_q;
  logic             mir_q, irq_q;

  wire [3:0] region   = wr_addr[15:12];
  wire       wr_latch = wr_en && region[3:2] == 2'b10;
  wire       wr_c     = wr_en && region == 4'hC;
  wire       wr_d     = wr_en && region == 4'hD;
  wire       wr_e     = wr_en && region == 4'hE;
  wire       wr_f     = wr_en && region == 4'hF;
  wire [1:0] f_sub    = wr_addr[11:10];
  wire       tick     = en_q[1] && cpu_ce && !wr_c;
  wire       wrap     = tick && cnt_q == {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      cnt_q   <= '0;
      en_q    <= '0;
      sel_q   <= '0;
      mir_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_latch) latch_q[{region[1:0], 2'b00} +: 4] <= wr_data[3:0];
      if (wr_c) en_q <= wr_data[2:0];
      else if (wr_d) en_q[1] <= en_q[0];
      if (wr_e) sel_q <= wr_data[3:0];
      if (wr_f && f_sub == 2'b10) mir_q <= wr_data[0];
      if (wr_c) begin
        if (wr_data[1]) cnt_q <= latch_q;
      end else if (tick) begin
        cnt_q <= wrap ? latch_q : cnt_q + 1'b1;
      end
      if (wr_c || wr_d) irq_q <= 1'b0;
      else if (wrap)    irq_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < PRG_N; i++) begin : g_prg
    logic [PRG_W-1:0] bank_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bank_q <= '0;
      else if (wr_f) begin
        if (sel_q == 4'(i + 1)) bank_q[3:0] <= wr_data[3:0];
        if (f_sub == 2'b00 && wr_addr[1:0] == 2'(i)) bank_q[4] <= wr_data[4];
      end
    end
    assign prg_banks[PRG_W*i +: PRG_W] = bank_q;
  end

  for (genvar j = 0; j < CHR_N; j++) begin : g_chr
    logic [CHR_W-1:0] bank_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bank_q <= '0;
      else if (wr_f && f_sub == 2'b11 && wr_addr[2:0] == 3'(j)) bank_q <= wr_data;
    end
    assign chr_banks[CHR_W*j +: CHR_W] = bank_q;
  end

  assign mirror = mir_q;
  assign irq    = irq_q;

  a_r4_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(cnt_q) == {CNT_W{1'b1}} && $past(cpu_ce));
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'hC && wr_data[1]) |=> cnt_q == $past(latch_q));
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr[15:12] == 4'hC || wr_addr[15:12] == 4'hD)) |=> !irq);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ce && !wr_en) |=> $stable(cnt_q) && $stable(irq));
  a_r8_mirror_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr[15:10] == 6'b111110) |=> $stable(mirror));
  a_r10_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[15] && !cpu_ce) |=> $stable(prg_banks) && $stable(chr_banks) && $stable(cnt_q));
endmodule

// File: tb/bank_irq_decoder_test.sv
module bank_irq_decoder_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_ce = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [19:0] prg_banks;
  logic [63:0] chr_banks;
  logic        mirror, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bank_irq_decoder uut (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .prg_banks(prg_banks),
    .chr_banks(chr_banks), .mirror(mirror), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {addr, data, bank3, bank2, bank1, bank0, mirror} expected after each write
  localparam int NV = 16;
  localparam logic [44:0] VEC [NV] = '{
    {16'hE000, 8'h01, 5'h00, 5'h00, 5'h00, 5'h00, 1'b0},  // R6 sel=1
    {16'hF400, 8'h1A, 5'h00, 5'h00, 5'h00, 5'h0A, 1'b0},  // R6 R9
    {16'hF001, 8'h10, 5'h00, 5'h00, 5'h10, 5'h00, 1'b0},  // R6 R7
    {16'hE000, 8'h03, 5'h00, 5'h00, 5'h10, 5'h00, 1'b0},
    {16'hF402, 8'h07, 5'h00, 5'h07, 5'h10, 5'h00, 1'b0},  // R9
    {16'hE000, 8'h24, 5'h00, 5'h07, 5'h10, 5'h00, 1'b0},  // R6 upper data ignored
    {16'hF800, 8'h0F, 5'h0F, 5'h07, 5'h10, 5'h00, 1'b1},  // R8 mirror
    {16'hE000, 8'h05, 5'h0F, 5'h07, 5'h10, 5'h00, 1'b1},  // R6 sel out of range
    {16'hF003, 8'h19, 5'h1F, 5'h07, 5'h10, 5'h00, 1'b1},  // R7
    {16'hF800, 8'h02, 5'h1F, 5'h07, 5'h10, 5'h00, 1'b0},  // R8
    {16'h7000, 8'h0F, 5'h1F, 5'h07, 5'h10, 5'h00, 1'b0},  // R10
    {16'hE000, 8'h00, 5'h1F, 5'h07, 5'h10, 5'h00, 1'b0},
    {16'hF002, 8'h10, 5'h1F, 5'h17, 5'h10, 5'h00, 1'b0},  // R7 sel=0
    {16'hE000, 8'h02, 5'h1F, 5'h17, 5'h10, 5'h00, 1'b0},
    {16'hFC05, 8'h3C, 5'h1F, 5'h17, 5'h1C, 5'h00, 1'b0},  // R6 R8
    {16'hF001, 8'h05, 5'h1F, 5'h17, 5'h05, 5'h00, 1'b0}   // R6 R7 R12
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    cpu_ce = 1'b1;
    repeat (n) @(negedge clk);
    cpu_ce = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 prg", 64'(prg_banks), 64'h0);
    chk("R1 chr", chr_banks, 64'h0);
    chk("R1 mirror", 64'(mirror), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][44:29], VEC[k][28:21]);
      chk($sformatf("R6/R7/R8/R9/R10/R12 vec%0d prg", k), 64'(prg_banks), 64'(VEC[k][20:1]));
      chk($sformatf("R8 vec%0d mirror", k), 64'(mirror), 64'(VEC[k][0]));
    end

    chk("R8 chr5", chr_banks, 64'h003C_0000_0000_0000 >> 8);
    wr(16'hFC08, 8'hA5);
    chk("R8 chr0 index from addr[2:0]", chr_banks, 64'h0000_3C00_0000_00A5);
    wr(16'h0FC0, 8'h55);
    chk("R10 low write chr", chr_banks, 64'h0000_3C00_0000_00A5);

    // R2 latch = FFF0 by nibbles, upper data bits ignored
    wr(16'h8123, 8'h50);
    wr(16'h9000, 8'h0F);
    wr(16'hA000, 8'hFF);
    wr(16'hB000, 8'h3F);
    wr(16'hC000, 8'hFA);   // R3 en=2, reload
    ticks(15);
    chk("R4 no irq before wrap", 64'(irq), 64'h0);
    ticks(1);
    chk("R4 irq on wrap", 64'(irq), 64'h1);
    repeat (5) @(negedge clk);
    chk("R11 irq held", 64'(irq), 64'h1);
    wr(16'hD000, 8'h00);   // R5 en0=0 -> stop
    chk("R5 ack clears", 64'(irq), 64'h0);
    ticks(20);
    chk("R5 counting stopped", 64'(irq), 64'h0);

    wr(16'hC000, 8'h03);   // R3 en=3 reload FFF0
    ticks(16);
    chk("R3 reload then wrap", 64'(irq), 64'h1);
    wr(16'hD000, 8'h00);   // R5 en1 <= en0 = 1
    chk("R5 ack clears running", 64'(irq), 64'h0);
    ticks(15);
    chk("R5 still counting pre", 64'(irq), 64'h0);
    ticks(1);
    chk("R5 still counting wrap", 64'(irq), 64'h1);
    wr(16'hC000, 8'h01);   // R3 no reload, stop
    chk("R3 write clears irq", 64'(irq), 64'h0);
    ticks(40);
    chk("R3 en1 clear stops", 64'(irq), 64'h0);

    wr(16'h8000, 8'hFE);   // R2 latch FFFE
    wr(16'hC000, 8'h02);
    ticks(1);
    chk("R2 FFFE one tick", 64'(irq), 64'h0);
    ticks(1);
    chk("R2 FFFE two ticks", 64'(irq), 64'h1);
    ticks(2);
    chk("R4 reload after wrap", 64'(irq), 64'h1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule